// File: doc/BRIEF.md
# Clear-on-read interrupt status controller

This block gathers sixteen single-cycle event strobes into two 8-bit sticky status registers. Each status register has a matching 8-bit enable register. Whenever any latched status bit has its enable bit set, the block pulls an active-low interrupt request line low.

A host uses a simple synchronous register port to service the request. It reads the status registers to find the cause, and it reads or writes the enable registers. A status read clears only the enabled bits of that register. Disabled causes stay recorded, so the host can poll them. A read-only register returns a 5-bit version code.

The port decodes addresses 01h (version), 03h and 04h (status), and 05h and 06h (enable). Read data is combinational: it shows the addressed register during the cycle in which the read strobe is high. A read's clearing side effect, and any write, take effect at the closing clock edge. Reset is synchronous and active high.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, both status registers read 00h, enable register 05h reads 00h, enable register 06h reads 01h, and the request line is high.
- R2: A pulse on bit n of `evt_a_i` sets bit n of status register 03h. A pulse on bit n of `evt_b_i` sets bit n of status register 04h. The bit is set at the next clock edge and stays set until it is cleared.
- R3: The request line is low exactly when some status bit is set and the enable bit in the same position is also set. It goes low in the cycle after the edge that latches such an event.
- R4: A read of 03h or 04h clears every bit of that register whose enable bit is set. Once no enabled bit remains set in either register, the request line returns high.
- R5: An event whose enable bit is clear still sets its status bit, and a host read shows it. It never pulls the request line low, and a status read does not clear it.
- R6: Enable register 05h masks status register 03h and enable register 06h masks status register 04h, bit for bit. Both can be written and read back. When an enable bit is set over a status bit that is already latched, the request line goes low in the cycle after the write edge.
- R7: If an event arrives in the same cycle as a read of its status register, the read returns the value from before the event, and the new bit stays set after the read.
- R8: Address 01h reads three zero bits above the 5-bit version code. Writes to 01h, 03h and 04h have no effect. Reads of any other unmapped address return 00h.
- R9: A read of one status register leaves the other status register unchanged. The request line stays low while the other register still holds an enabled bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_a_i | input | 8 | Event strobes for status register 03h |
| evt_b_i | input | 8 | Event strobes for status register 04h |
| reg_addr_i | input | 8 | Register address |
| reg_rd_i | input | 1 | Read strobe; clears enabled status bits at the clock edge |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
A table of event and enable patterns drives the main function. The patterns include:
- a single enabled cause;
- causes that are only disabled;
- full overlap of events and enables;
- disjoint events and enables;
- mixed halves split across both registers.

For every pattern the bench checks the request level, the value each status register reads, and the value left behind after a read. This separates three failure modes: clearing too much, clearing too little, and masking the request wrongly. Directed cases then cover the following:
- the power-on cause that is enabled at reset;
- setting an enable bit late over a stale cause;
- an event that collides with a read;
- independence between the two registers;
- the behaviour of ignored writes and unmapped addresses.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int REG_W     = 8;
    localparam int ADDR_W    = 8;
    localparam int VER_W     = 5;
    localparam int NUM_BANKS = 2;

    localparam logic [ADDR_W-1:0] ADDR_VER = 8'h01;
    localparam int                ST_BASE  = 3;
    localparam int                EN_BASE  = ST_BASE + NUM_BANKS;

    typedef logic [REG_W-1:0] reg_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        reg_t              wdata;
    } reg_req_t;

    typedef struct packed {
        reg_t status;
        reg_t enable;
    } bank_view_t;

    // Bank 1 powers up with its lowest cause (power-on) enabled.
    function automatic reg_t en_reset_of(int bank);
        return (bank == 1) ? reg_t'(1) : '0;
    endfunction

    function automatic logic [ADDR_W-1:0] st_addr_of(int bank);
        return ADDR_W'(ST_BASE + bank);
    endfunction

    function automatic logic [ADDR_W-1:0] en_addr_of(int bank);
        return ADDR_W'(EN_BASE + bank);
    endfunction

endpackage

// File: rtl/evt_irq_bank.sv
module evt_irq_bank
    import evt_irq_pkg::*;
#(
    parameter reg_t              EN_RESET = '0,
    parameter logic [ADDR_W-1:0] ST_ADDR  = 8'h03,
    parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h05
) (
    input  logic       clk,
    input  logic       rst,
    input  reg_req_t   req,
    input  reg_t       evt_i,
    output bank_view_t view_o,
    output logic       pending_o
);

    reg_t status_q;
    reg_t en_q;
    logic rd_hit;
    logic wr_hit;

    assign rd_hit = req.rd && (req.addr == ST_ADDR);
    assign wr_hit = req.wr && (req.addr == EN_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            en_q     <= EN_RESET;
        end else begin
            status_q <= (rd_hit ? (status_q & ~en_q) : status_q) | evt_i;
            if (wr_hit) begin
                en_q <= req.wdata;
            end
        end
    end

    assign view_o.status = status_q;
    assign view_o.enable = en_q;
    assign pending_o     = |(status_q & en_q);

    // R2
    evt_latched_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(evt_i)) == $past(evt_i)));

    // R4
    rd_clears_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> ((status_q & $past(en_q) & ~$past(evt_i)) == '0));

    // R5
    disabled_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status_q) & ~$past(en_q) & ~status_q) == '0));

    // R6
    en_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (en_q == $past(req.wdata)));

    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(en_q));

endmodule

// File: rtl/evt_irq_rdmux.sv
module evt_irq_rdmux
    import evt_irq_pkg::*;
#(
    parameter logic [VER_W-1:0] VERSION_CODE = 5'h06
) (
    input  logic [ADDR_W-1:0]                addr_i,
    input  bank_view_t [NUM_BANKS-1:0]       views_i,
    output reg_t                             rdata_o
);

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_VER) begin
            rdata_o = {{(REG_W-VER_W){1'b0}}, VERSION_CODE};
        end
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (addr_i == st_addr_of(i)) rdata_o = views_i[i].status;
            if (addr_i == en_addr_of(i)) rdata_o = views_i[i].enable;
        end
    end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter logic [4:0] VERSION_CODE = 5'h06
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] evt_a_i,
    input  logic [7:0] evt_b_i,
    input  logic [7:0] reg_addr_i,
    input  logic       reg_rd_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       irq_n_o
);

    reg_req_t                   req;
    reg_t       [NUM_BANKS-1:0] evt_vec;
    bank_view_t [NUM_BANKS-1:0] views;
    logic       [NUM_BANKS-1:0] pending;

    assign req.rd    = reg_rd_i;
    assign req.wr    = reg_wr_i;
    assign req.addr  = reg_addr_i;
    assign req.wdata = reg_wdata_i;
    assign evt_vec   = {evt_b_i, evt_a_i};

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        evt_irq_bank #(
            .EN_RESET (en_reset_of(g)),
            .ST_ADDR  (st_addr_of(g)),
            .EN_ADDR  (en_addr_of(g))
        ) bank_i (
            .clk       (clk),
            .rst       (rst),
            .req       (req),
            .evt_i     (evt_vec[g]),
            .view_o    (views[g]),
            .pending_o (pending[g])
        );
    end

    evt_irq_rdmux #(
        .VERSION_CODE (VERSION_CODE)
    ) rdmux_i (
        .addr_i  (reg_addr_i),
        .views_i (views),
        .rdata_o (reg_rdata_o)
    );

    assign irq_n_o = ~|pending;

    // R3
    irq_follows_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (|((evt_a_i & views[0].enable) | (evt_b_i & views[1].enable)) && !reg_wr_i)
            |=> !irq_n_o);

endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;

    localparam logic [4:0] VER = 5'h06;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] evt_a_i, evt_b_i, reg_addr_i, reg_wdata_i, reg_rdata_o;
    logic       reg_rd_i, reg_wr_i, irq_n_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    evt_irq_ctrl #(.VERSION_CODE(VER)) dut_i (
        .clk(clk), .rst(rst), .evt_a_i(evt_a_i), .evt_b_i(evt_b_i),
        .reg_addr_i(reg_addr_i), .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_n_o(irq_n_o)
    );

    // {evt_a, evt_b, en_a, en_b}
    localparam logic [31:0] VEC [8] = '{
        32'h01_00_01_00, 32'h80_00_00_00, 32'h00_80_00_FF, 32'hA5_5A_0F_F0,
        32'hFF_FF_FF_FF, 32'h3C_00_C3_00, 32'h00_01_00_01, 32'h42_24_40_00
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_rd_i = 1'b1;
        #1 d = reg_rdata_o;
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        evt_a_i = a; evt_b_i = b;
        @(negedge clk);
        evt_a_i = '0; evt_b_i = '0;
    endtask

    task automatic clear_all();
        logic [7:0] d;
        wr(8'h05, 8'hFF); wr(8'h06, 8'hFF);
        rd(8'h03, d); rd(8'h04, d);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; evt_a_i = '0; evt_b_i = '0; reg_addr_i = '0;
        reg_rd_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {7'b0, irq_n_o}, 8'h01);
        rd(8'h05, d); chk("R1 en1", d, 8'h00);
        rd(8'h06, d); chk("R1 en2", d, 8'h01);
        rd(8'h03, d); chk("R1 st1", d, 8'h00);
        rd(8'h04, d); chk("R1 st2", d, 8'h00);

        // R3 power-on cause enabled by default
        pulse(8'h00, 8'h01);
        chk("R3 por irq", {7'b0, irq_n_o}, 8'h00);
        rd(8'h04, d); chk("R2 por st2", d, 8'h01);
        chk("R4 por irq release", {7'b0, irq_n_o}, 8'h01);

        // table walk: R2 R3 R4 R5 R6
        foreach (VEC[i]) begin
            logic [7:0] ea, eb, na, nb;
            {ea, eb, na, nb} = VEC[i];
            clear_all();
            wr(8'h05, na); wr(8'h06, nb);
            rd(8'h05, d); chk("R6 en1 readback", d, na);
            rd(8'h06, d); chk("R6 en2 readback", d, nb);
            pulse(ea, eb);
            chk("R3 irq level", {7'b0, irq_n_o}, {7'b0, ~|((ea & na) | (eb & nb))});
            rd(8'h03, d); chk("R2 st1", d, ea);
            rd(8'h04, d); chk("R2 st2", d, eb);
            chk("R4 irq after reads", {7'b0, irq_n_o}, 8'h01);
            rd(8'h03, d); chk("R5 st1 sticky", d, ea & ~na);
            rd(8'h04, d); chk("R5 st2 sticky", d, eb & ~nb);
        end

        // R6 late enable over stale cause
        clear_all();
        wr(8'h05, 8'h00); wr(8'h06, 8'h00);
        pulse(8'h08, 8'h00);
        chk("R5 disabled no irq", {7'b0, irq_n_o}, 8'h01);
        wr(8'h05, 8'h08);
        chk("R6 late enable irq", {7'b0, irq_n_o}, 8'h00);
        rd(8'h03, d); chk("R6 late st1", d, 8'h08);
        chk("R4 late release", {7'b0, irq_n_o}, 8'h01);

        // R7 event colliding with read
        clear_all();
        pulse(8'h01, 8'h00);
        @(negedge clk);
        reg_addr_i = 8'h03; reg_rd_i = 1'b1; evt_a_i = 8'h04;
        #1 d = reg_rdata_o;
        chk("R7 old value", d, 8'h01);
        @(negedge clk);
        reg_rd_i = 1'b0; evt_a_i = '0;
        chk("R7 irq held", {7'b0, irq_n_o}, 8'h00);
        rd(8'h03, d); chk("R7 new bit kept", d, 8'h04);

        // R9 independence of the two registers
        clear_all();
        pulse(8'h10, 8'h20);
        rd(8'h03, d); chk("R9 st1", d, 8'h10);
        chk("R9 irq still low", {7'b0, irq_n_o}, 8'h00);
        rd(8'h04, d); chk("R9 st2 untouched", d, 8'h20);
        chk("R9 irq release", {7'b0, irq_n_o}, 8'h01);

        // R8 version, ignored writes, unmapped reads
        wr(8'h01, 8'hFF); wr(8'h03, 8'hFF); wr(8'h04, 8'hFF);
        rd(8'h01, d); chk("R8 version", d, {3'b000, VER});
        rd(8'h03, d); chk("R8 st1 write ignored", d, 8'h00);
        rd(8'h04, d); chk("R8 st2 write ignored", d, 8'h00);
        chk("R8 irq", {7'b0, irq_n_o}, 8'h01);
        rd(8'h00, d); chk("R8 unmapped 00", d, 8'h00);
        rd(8'h07, d); chk("R8 unmapped 07", d, 8'h00);
        rd(8'hFF, d); chk("R8 unmapped FF", d, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule